// File: doc/BRIEF.md
# Fault Dispatch and Escalation Unit

This unit takes one synchronous fault event per cycle and decides where it goes. The event belongs to one of four classes: memory-protection fault, bus fault, usage fault, or a bus error on a vector fetch. The decision uses four things: whether the handler for that class is enabled, the preempt level programmed for the class, the level of the code that is running now, and any stronger exception that arrives in the same cycle. The unit either asks for the class's own handler, leaves the fault pending in its class, sends it up to the hard fault handler, or locks the core. A fault in one of the first three classes that is raised while the hard fault or NMI handler runs locks the unit. Lockup lasts until reset and blocks every later request.

Independently of that decision, every event leaves a cause bit in a packed 32-bit fault status word. Memory-protection causes sit in byte 0, bus causes in byte 1 and usage causes in bits 31:16. A separate hard status word records vector-fetch errors and escalations. Two address registers keep the first faulting address of the memory-protection and bus classes. Software clears any status bit by writing 1 to it through a write port with byte lanes, so byte, halfword and word writes all work.

Levels are unsigned, and a smaller value means a higher priority. `run_lvl` is one bit wider than a class level, so the value 2^PW stands for thread code, where no handler is running. Dispatch outputs are one-cycle pulses (pending flags are levels). All control and status pins are plain, with no handshake.

Top module: `fault_escalate`

## Requirements
- R1: A fault of class 0 (memory), 1 (bus) or 2 (usage) raises `req_own[class]` for exactly the cycle after the event when all of these hold: the class handler is enabled, the class level is numerically below `run_lvl`, and no coincident exception has a level below the class level.
- R2: When the R1 conditions hold except that a coincident exception (`coin_valid`) has a level strictly below the class level, the unit sets `pend_q[class]` instead of a request. `pend_q[class]` stays set until the cycle after `pend_take[class]` is high. If a new pend and the take arrive together, the bit stays set.
- R3: A class 0–2 fault whose handler is disabled, or whose level is greater than or equal to `run_lvl`, raises `req_hard` for the cycle after the event and sets escalation bit 30 of `hfs`. At most one of `req_own`/`req_hard` is high in any cycle.
- R4: A class 3 event (vector-fetch bus error) always raises `req_hard` on the next cycle, unless the unit is locked. It sets bit 1 of `hfs` and leaves `fsw` unchanged.
- R5: A class 0–2 fault while `in_hard` or `in_nmi` is high sets `locked` on the next cycle, and that event produces no request or pend. `locked` stays high until reset, and while it is high no request or new pend is produced.
- R6: Cause encoding: for memory and bus faults, `ev_cause[2:0]` values 0–6 set bit `cause` of byte 0 or byte 1 respectively, and value 7 sets no cause bit. For usage faults, `ev_cause[3:0]` sets bit `16+cause`. Status is recorded even when the unit is locked.
- R7: A write with `fsw_we` or `hfs_we` clears only the bits that are 1 in `sw_wdata` within lanes enabled by `sw_be` (bit n enables byte n). All other bits keep their value. `hfs` implements only bits 1 and 30.
- R8: A memory or bus fault with `ev_addr_ok` high sets the address-valid bit of its byte (bit 7 for memory, bit 15 for bus) and stores `ev_addr` in `mm_addr` or `bus_addr`. A fault with `ev_addr_ok` low, such as an imprecise bus fault, sets neither.
- R9: While an address-valid bit is set and not being cleared, its address register keeps its value even if new faults with addresses arrive. A capture in the same cycle as the clear of the valid bit stores the new address.
- R10: If a fault sets a status bit in the same cycle as a write-one-to-clear of that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Fault event strobe |
| ev_class | input | 2 | 0 memory, 1 bus, 2 usage, 3 vector-fetch bus error |
| ev_cause | input | 4 | Cause index within the class |
| ev_addr | input | AW | Faulting address |
| ev_addr_ok | input | 1 | Faulting address is known |
| hnd_en | input | 3 | Handler enable per class 0–2 |
| lvl_mm | input | PW | Preempt level of memory faults |
| lvl_bus | input | PW | Preempt level of bus faults |
| lvl_usg | input | PW | Preempt level of usage faults |
| run_lvl | input | PW+1 | Level of running code, 2^PW for thread |
| in_hard | input | 1 | Hard fault handler is executing |
| in_nmi | input | 1 | NMI handler is executing |
| coin_valid | input | 1 | Another exception arrives this cycle |
| coin_lvl | input | PW | Level of that exception |
| pend_take | input | 3 | Pended class is being taken, clears its pend bit |
| fsw_we | input | 1 | Write-one-to-clear strobe for `fsw` |
| hfs_we | input | 1 | Write-one-to-clear strobe for `hfs` |
| sw_be | input | 4 | Byte lanes of the write |
| sw_wdata | input | 32 | Write data, ones mark bits to clear |
| req_own | output | 3 | Request for the class's own handler |
| req_hard | output | 1 | Request for the hard fault handler |
| pend_q | output | 3 | Pending fault per class |
| locked | output | 1 | Lockup state |
| fsw | output | 32 | Fault status word: usage, bus, memory bytes |
| hfs | output | 32 | Hard status: bit 1 vector fetch, bit 30 escalated |
| mm_addr | output | AW | First memory-fault address |
| bus_addr | output | AW | First bus-fault address |

## Verification
The assertions assume two-state inputs, an `ev_class` and `ev_cause` that are meaningful whenever `ev_valid` is high, and a reset that is asserted before the first event. Because lockup is permanent until reset, the random phase holds `in_hard` and `in_nmi` low and leaves lockup to a directed sequence at the end. Levels, enables, coincident exceptions, takes and clear writes with random lanes are drawn freely, so pends, escalations and same-cycle set/clear collisions all occur.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {
    FC_MEM = 2'd0,
    FC_BUS = 2'd1,
    FC_USE = 2'd2,
    FC_VEC = 2'd3
  } fclass_e;

  localparam int NCLS     = 3;
  localparam int NADDR    = 2;
  localparam int AV_BIT   = 7;
  localparam int HFS_VEC  = 1;
  localparam int HFS_ESC  = 30;
  localparam logic [31:0] HFS_MASK = (32'h1 << HFS_VEC) | (32'h1 << HFS_ESC);
endpackage

// File: rtl/fe_route.sv
module fe_route
  import fe_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [1:0]          ev_class,
  input  logic [NCLS-1:0]     hnd_en,
  input  logic [NCLS*PW-1:0]  lvl_all,
  input  logic [PW:0]         run_lvl,
  input  logic                in_hard,
  input  logic                in_nmi,
  input  logic                coin_valid,
  input  logic [PW-1:0]       coin_lvl,
  input  logic [NCLS-1:0]     pend_take,
  output logic [NCLS-1:0]     req_own,
  output logic                req_hard,
  output logic [NCLS-1:0]     pend_q,
  output logic                locked,
  output logic                esc_set
);
  fclass_e       cls;
  logic [PW-1:0] f_lvl;
  logic          f_en;
  logic          is_vec, is_cls, lock_hit, live, can_own, beaten, hard_new;
  logic [NCLS-1:0] own_new, pend_new;

  assign cls = fclass_e'(ev_class);

  always_comb begin
    f_lvl = '0;
    f_en  = 1'b0;
    for (int i = 0; i < NCLS; i++) begin
      if (ev_class == 2'(i)) begin
        f_lvl = lvl_all[i*PW +: PW];
        f_en  = hnd_en[i];
      end
    end
  end

  assign is_vec   = ev_valid && (cls == FC_VEC);
  assign is_cls   = ev_valid && (cls != FC_VEC);
  assign lock_hit = is_cls && (in_hard || in_nmi);
  assign live     = is_cls && !lock_hit && !locked;
  assign can_own  = f_en && ({1'b0, f_lvl} < run_lvl);
  assign beaten   = coin_valid && (coin_lvl < f_lvl);
  assign esc_set  = live && !can_own;
  assign hard_new = !locked && (is_vec || esc_set);

  for (genvar gi = 0; gi < NCLS; gi++) begin : g_cls
    assign own_new[gi]  = live && can_own && !beaten && (ev_class == 2'(gi));
    assign pend_new[gi] = live && can_own && beaten && (ev_class == 2'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_own  <= '0;
      req_hard <= 1'b0;
      pend_q   <= '0;
      locked   <= 1'b0;
    end else begin
      req_own  <= own_new;
      req_hard <= hard_new;
      pend_q   <= (pend_q & ~pend_take) | pend_new;
      locked   <= locked | lock_hit;
    end
  end

  // R3: requests are mutually exclusive
  assert_one_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_own, req_hard}));

  // R4: vector-fetch error reaches hard fault
  assert_vec_to_hard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_class == 2'd3 && !locked) |=> req_hard);

  // R5: fault inside hard fault or NMI locks up
  assert_lock_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_class != 2'd3 && (in_hard || in_nmi)) |=> locked);

  // R5: lockup silences all requests
  assert_lock_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (req_own == '0 && !req_hard));

  // R2: a pended class never requests its handler in the same cycle
  assert_pend_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_new) |=> ((req_own & $past(pend_new)) == '0));
endmodule

// File: rtl/fe_status.sv
module fe_status
  import fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [1:0]       ev_class,
  input  logic [3:0]       ev_cause,
  input  logic             ev_addr_ok,
  input  logic             esc_set,
  input  logic             fsw_we,
  input  logic             hfs_we,
  input  logic [3:0]       sw_be,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      fsw,
  output logic [31:0]      hfs,
  output logic [NADDR-1:0] cap
);
  fclass_e     cls;
  logic [31:0] lane_m, clr_f, clr_h, set_f, set_h;

  assign cls = fclass_e'(ev_class);

  function automatic logic [7:0] byte_bits(input logic [2:0] c, input logic aok);
    logic [7:0] b;
    b = (c == 3'd7) ? 8'h00 : (8'h01 << c);
    if (aok) b[AV_BIT] = 1'b1;
    return b;
  endfunction

  assign lane_m = {{8{sw_be[3]}}, {8{sw_be[2]}}, {8{sw_be[1]}}, {8{sw_be[0]}}};
  assign clr_f  = fsw_we ? (sw_wdata & lane_m) : '0;
  assign clr_h  = hfs_we ? (sw_wdata & lane_m & HFS_MASK) : '0;

  always_comb begin
    set_f = '0;
    if (ev_valid) begin
      case (cls)
        FC_MEM:  set_f[7:0]   = byte_bits(ev_cause[2:0], ev_addr_ok);
        FC_BUS:  set_f[15:8]  = byte_bits(ev_cause[2:0], ev_addr_ok);
        FC_USE:  set_f[31:16] = 16'h0001 << ev_cause;
        default: set_f = '0;
      endcase
    end
  end

  always_comb begin
    set_h = '0;
    set_h[HFS_VEC] = ev_valid && (cls == FC_VEC);
    set_h[HFS_ESC] = esc_set;
  end

  assign cap[0] = set_f[AV_BIT]     && (!fsw[AV_BIT]     || clr_f[AV_BIT]);
  assign cap[1] = set_f[8 + AV_BIT] && (!fsw[8 + AV_BIT] || clr_f[8 + AV_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsw <= '0;
      hfs <= '0;
    end else begin
      fsw <= (fsw & ~clr_f) | set_f;
      hfs <= (hfs & ~clr_h) | set_h;
    end
  end

  // R10: a set in the same cycle as a clear wins
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_f) |=> ((fsw & $past(set_f)) == $past(set_f)));

  // R7: disabled lanes and no event leave the word alone
  assert_lane_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && (!fsw_we || sw_be == 4'h0)) |=> $stable(fsw));

  // R4: vector-fetch error never touches the class status word
  assert_vec_keeps_fsw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_class == 2'd3 && !fsw_we) |=> $stable(fsw));
endmodule

// File: rtl/fe_addr_cap.sv
module fe_addr_cap #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dout <= '0;
    else if (cap) dout <= din;
  end
endmodule

// File: rtl/fault_escalate.sv
module fault_escalate
  import fe_pkg::*;
#(
  parameter int PW = 3,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [1:0]    ev_class,
  input  logic [3:0]    ev_cause,
  input  logic [AW-1:0] ev_addr,
  input  logic          ev_addr_ok,
  input  logic [2:0]    hnd_en,
  input  logic [PW-1:0] lvl_mm,
  input  logic [PW-1:0] lvl_bus,
  input  logic [PW-1:0] lvl_usg,
  input  logic [PW:0]   run_lvl,
  input  logic          in_hard,
  input  logic          in_nmi,
  input  logic          coin_valid,
  input  logic [PW-1:0] coin_lvl,
  input  logic [2:0]    pend_take,
  input  logic          fsw_we,
  input  logic          hfs_we,
  input  logic [3:0]    sw_be,
  input  logic [31:0]   sw_wdata,
  output logic [2:0]    req_own,
  output logic          req_hard,
  output logic [2:0]    pend_q,
  output logic          locked,
  output logic [31:0]   fsw,
  output logic [31:0]   hfs,
  output logic [AW-1:0] mm_addr,
  output logic [AW-1:0] bus_addr
);
  logic                esc_set;
  logic [NADDR-1:0]    cap;
  logic [AW-1:0]       far_q [NADDR];
  logic [NCLS*PW-1:0]  lvl_all;

  assign lvl_all = {lvl_usg, lvl_bus, lvl_mm};

  fe_route #(.PW(PW)) u_route (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_class(ev_class),
    .hnd_en(hnd_en), .lvl_all(lvl_all), .run_lvl(run_lvl),
    .in_hard(in_hard), .in_nmi(in_nmi), .coin_valid(coin_valid),
    .coin_lvl(coin_lvl), .pend_take(pend_take), .req_own(req_own),
    .req_hard(req_hard), .pend_q(pend_q), .locked(locked), .esc_set(esc_set)
  );

  fe_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_class(ev_class),
    .ev_cause(ev_cause), .ev_addr_ok(ev_addr_ok), .esc_set(esc_set),
    .fsw_we(fsw_we), .hfs_we(hfs_we), .sw_be(sw_be), .sw_wdata(sw_wdata),
    .fsw(fsw), .hfs(hfs), .cap(cap)
  );

  for (genvar gi = 0; gi < NADDR; gi++) begin : g_far
    fe_addr_cap #(.AW(AW)) u_cap (
      .clk(clk), .rst_n(rst_n), .cap(cap[gi]), .din(ev_addr), .dout(far_q[gi])
    );
  end

  assign mm_addr  = far_q[0];
  assign bus_addr = far_q[1];

  // R8: a memory fault with a known address marks it valid
  assert_addr_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_class == 2'd0 && ev_addr_ok) |=> fsw[7]);

  // R9: a held memory-fault address is not overwritten
  assert_mm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsw[7] && !(fsw_we && sw_be[0] && sw_wdata[7])) |=> $stable(mm_addr));

  // R9: a held bus-fault address is not overwritten
  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsw[15] && !(fsw_we && sw_be[1] && sw_wdata[15])) |=> $stable(bus_addr));
endmodule

// File: tb/sim_fault_escalate.sv
module sim_fault_escalate;
  localparam int PW = 3;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          ev_valid, ev_addr_ok, in_hard, in_nmi, coin_valid, fsw_we, hfs_we;
  logic [1:0]    ev_class;
  logic [3:0]    ev_cause, sw_be;
  logic [AW-1:0] ev_addr;
  logic [2:0]    hnd_en, pend_take, req_own, pend_q;
  logic [PW-1:0] lvl_mm, lvl_bus, lvl_usg, coin_lvl;
  logic [PW:0]   run_lvl;
  logic [31:0]   sw_wdata, fsw, hfs;
  logic          req_hard, locked;
  logic [AW-1:0] mm_addr, bus_addr;

  fault_escalate #(.PW(PW), .AW(AW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0]   e_fsw, e_hfs;
  logic [AW-1:0] e_mma, e_bua;
  logic [2:0]    e_req, e_pend;
  logic          e_hard, e_lock;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic idle();
    ev_valid = 0; ev_class = 0; ev_cause = 0; ev_addr = 0; ev_addr_ok = 0;
    in_hard = 0; in_nmi = 0; coin_valid = 0; coin_lvl = 0; pend_take = 0;
    fsw_we = 0; hfs_we = 0; sw_be = 0; sw_wdata = 0;
  endtask

  function automatic logic [PW-1:0] cls_lvl(input logic [1:0] c);
    case (c)
      2'd0:    return lvl_mm;
      2'd1:    return lvl_bus;
      default: return lvl_usg;
    endcase
  endfunction

  // Expected next state from the requirements
  task automatic model();
    logic [31:0] lanes, clr, hclr, setv, hset;
    logic [2:0] nreq, npend;
    logic nhard, nlock, ok;
    logic [PW-1:0] fl;
    lanes = {{8{sw_be[3]}}, {8{sw_be[2]}}, {8{sw_be[1]}}, {8{sw_be[0]}}};
    clr  = fsw_we ? (sw_wdata & lanes) : 32'h0;
    hclr = hfs_we ? (sw_wdata & lanes & 32'h4000_0002) : 32'h0;
    setv = 0; hset = 0; nreq = 0; npend = 0; nhard = 0; nlock = e_lock;
    if (ev_valid) begin
      if (ev_class == 2'd3) begin
        hset[1] = 1'b1;
        nhard = !e_lock;
      end else begin
        if (ev_class == 2'd2) setv[16 + ev_cause] = 1'b1;
        else begin
          if (ev_cause[2:0] != 3'd7) setv[8*ev_class + ev_cause[2:0]] = 1'b1;
          if (ev_addr_ok) setv[8*ev_class + 7] = 1'b1;
        end
        if (in_hard || in_nmi) nlock = 1'b1;
        else if (!e_lock) begin
          fl = cls_lvl(ev_class);
          ok = hnd_en[ev_class] && ({1'b0, fl} < run_lvl);
          if (!ok) begin nhard = 1'b1; hset[30] = 1'b1; end
          else if (coin_valid && coin_lvl < fl) npend[ev_class] = 1'b1;
          else nreq[ev_class] = 1'b1;
        end
      end
    end
    if (setv[7] && (!e_fsw[7] || clr[7])) e_mma = ev_addr;
    if (setv[15] && (!e_fsw[15] || clr[15])) e_bua = ev_addr;
    e_fsw  = (e_fsw & ~clr) | setv;
    e_hfs  = (e_hfs & ~hclr) | hset;
    e_req  = nreq;
    e_hard = nhard;
    e_pend = (e_pend & ~pend_take) | npend;
    e_lock = nlock;
  endtask

  task automatic step();
    model();
    @(posedge clk);
    @(negedge clk);
    chk("R1 req_own", {29'h0, req_own}, {29'h0, e_req});
    chk("R3 req_hard", {31'h0, req_hard}, {31'h0, e_hard});
    chk("R2 pend_q", {29'h0, pend_q}, {29'h0, e_pend});
    chk("R5 locked", {31'h0, locked}, {31'h0, e_lock});
    chk("R6 fsw", fsw, e_fsw);
    chk("R4 hfs", hfs, e_hfs);
    chk("R8 mm_addr", mm_addr, e_mma);
    chk("R9 bus_addr", bus_addr, e_bua);
    idle();
  endtask

  task automatic fault(input logic [1:0] c, input logic [3:0] cause,
                       input logic aok, input logic [31:0] a);
    ev_valid = 1; ev_class = c; ev_cause = cause; ev_addr_ok = aok; ev_addr = a;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    hnd_en = 0; lvl_mm = 0; lvl_bus = 0; lvl_usg = 0; run_lvl = 4'd8;
    e_fsw = 0; e_hfs = 0; e_mma = 0; e_bua = 0; e_req = 0; e_pend = 0;
    e_hard = 0; e_lock = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R5 reset locked", {31'h0, locked}, 32'h0);
    chk("R6 reset fsw", fsw, 32'h0);
    chk("R4 reset hfs", hfs, 32'h0);
    chk("R1 reset req", {28'h0, req_own, req_hard}, 32'h0);

    // random phase, no lockup
    for (int n = 0; n < 3000; n++) begin
      hnd_en  = 3'($urandom);
      lvl_mm  = PW'($urandom); lvl_bus = PW'($urandom); lvl_usg = PW'($urandom);
      run_lvl = (PW+1)'($urandom_range(0, 8));
      if ($urandom_range(0, 2) != 0)
        fault(2'($urandom), 4'($urandom), 1'($urandom), $urandom);
      coin_valid = 1'($urandom); coin_lvl = PW'($urandom);
      pend_take  = 3'($urandom) & 3'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        fsw_we = 1; sw_be = 4'($urandom); sw_wdata = $urandom;
      end
      if ($urandom_range(0, 5) == 0) begin
        hfs_we = 1; sw_be = 4'($urandom); sw_wdata = $urandom;
      end
      step();
    end

    // clear everything (R7)
    pend_take = 3'b111; fsw_we = 1; hfs_we = 1; sw_be = 4'hF; sw_wdata = 32'hFFFF_FFFF;
    step();
    chk("R7 full clear fsw", fsw, 32'h0);
    chk("R7 full clear hfs", hfs, 32'h0);

    // R1 + R8: own handler, address captured
    hnd_en = 3'b111; lvl_mm = 3; lvl_bus = 2; lvl_usg = 5; run_lvl = 5;
    fault(2'd1, 4'd3, 1'b1, 32'h0000_1000);
    step();
    chk("R1 bus own request", {29'h0, req_own}, 32'h2);
    chk("R8 bus byte", {24'h0, fsw[15:8]}, 32'h88);
    chk("R8 bus address", bus_addr, 32'h0000_1000);

    // R9: held address not overwritten
    fault(2'd1, 4'd1, 1'b1, 32'h0000_2000);
    step();
    chk("R9 bus address held", bus_addr, 32'h0000_1000);

    // R7: masked lane leaves bus byte alone
    fsw_we = 1; sw_be = 4'b1101; sw_wdata = 32'hFFFF_FFFF;
    step();
    chk("R7 masked lane", {24'h0, fsw[15:8]}, 32'h8A);

    // R9: capture in the same cycle as clearing valid
    fault(2'd1, 4'd0, 1'b1, 32'h0000_3000);
    fsw_we = 1; sw_be = 4'b0010; sw_wdata = 32'h0000_8000;
    step();
    chk("R9 recapture on clear", bus_addr, 32'h0000_3000);

    // R2: pended by a stronger coincident exception, then taken
    fault(2'd0, 4'd1, 1'b0, 32'h0);
    coin_valid = 1; coin_lvl = 1;
    step();
    chk("R2 pend set", {29'h0, pend_q}, 32'h1);
    chk("R2 no own request", {29'h0, req_own}, 32'h0);
    pend_take = 3'b001;
    step();
    chk("R2 pend taken", {29'h0, pend_q}, 32'h0);

    // R3: disabled handler, then equal level
    hnd_en = 3'b011;
    fault(2'd2, 4'd4, 1'b0, 32'h0);
    step();
    chk("R3 disabled escalates", {31'h0, req_hard}, 32'h1);
    chk("R3 escalation bit", {31'h0, hfs[30]}, 32'h1);
    hnd_en = 3'b111; lvl_usg = 5; run_lvl = 5;
    fault(2'd2, 4'd5, 1'b0, 32'h0);
    step();
    chk("R3 equal level escalates", {28'h0, req_own, req_hard}, 32'h1);

    // R4: vector fetch
    fault(2'd3, 4'd2, 1'b1, 32'h0000_4000);
    step();
    chk("R4 vector hard", {31'h0, req_hard}, 32'h1);
    chk("R4 vector bit", {31'h0, hfs[1]}, 32'h1);

    // R10: set and clear of the same bit together
    fault(2'd0, 4'd2, 1'b0, 32'h0);
    fsw_we = 1; sw_be = 4'b0001; sw_wdata = 32'h0000_0004;
    step();
    chk("R10 set wins", {31'h0, fsw[2]}, 32'h1);

    // R6: top usage bit, and memory cause 7 with no address
    fault(2'd2, 4'd15, 1'b0, 32'h0);
    step();
    chk("R6 usage bit 31", {31'h0, fsw[31]}, 32'h1);
    fsw_we = 1; sw_be = 4'h1; sw_wdata = 32'hFF;
    step();
    fault(2'd0, 4'd7, 1'b0, 32'h0);
    step();
    chk("R6 cause 7 sets nothing", {24'h0, fsw[7:0]}, 32'h0);

    // R8: imprecise bus fault leaves valid clear
    fsw_we = 1; sw_be = 4'h2; sw_wdata = 32'hFF00;
    step();
    fault(2'd1, 4'd2, 1'b0, 32'h0000_5000);
    step();
    chk("R8 imprecise no valid", {31'h0, fsw[15]}, 32'h0);
    chk("R8 imprecise address kept", bus_addr, 32'h0000_3000);

    // R5: lockup inside NMI, then silence
    fault(2'd2, 4'd1, 1'b0, 32'h0);
    in_nmi = 1;
    step();
    chk("R5 lock entered", {31'h0, locked}, 32'h1);
    chk("R5 no request on lock", {28'h0, req_own, req_hard}, 32'h0);
    hnd_en = 3'b111; lvl_mm = 0; run_lvl = 8;
    fault(2'd0, 4'd3, 1'b1, 32'h0000_6000);
    step();
    chk("R5 locked silences", {28'h0, req_own, req_hard}, 32'h0);
    chk("R6 status while locked", {31'h0, fsw[3]}, 32'h1);
    fault(2'd3, 4'd0, 1'b0, 32'h0);
    step();
    chk("R5 locked stays", {31'h0, locked}, 32'h1);
    chk("R5 no hard while locked", {31'h0, req_hard}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule